// File: doc/BRIEF.md
# Oversampled Asynchronous Receiver with Address Filtering

This block receives asynchronous serial frames on a single line and hands each accepted frame to a consumer as a data byte plus one extra bit. A strobe input supplies sixteen ticks per bit period. While no frame is in progress, the block compares successive tick samples of the line and looks for a high-to-low step. That step restarts a local phase counter, so every bit boundary of the frame lines up with the counter's wrap. Each bit is decided by a two-out-of-three vote on the samples taken at counter phases 7, 8 and 9. A start bit that votes high is treated as noise, and the receiver goes back to hunting for a falling edge.

Frame length is marked by a sentinel. On each start the capture register is filled with ones. Zeros then arrive at the low end and ones leave at the top, so the frame is over once the start bit's zero reaches the watched top position. Two frame shapes are supported: 10-bit (start, eight data bits sent LSB first, stop) and 11-bit (start, eight data bits, a ninth bit, stop). At the last bit of a frame, the result is committed to the output only if the output holder is empty and the address filter allows it. The output follows a valid/take scheme. `out_valid` stays high until `out_take` is pulsed. There is no back-pressure on the line: a frame that completes while `out_valid` is high is dropped without trace. The consumer must therefore take each frame before the next one ends.

Top module: `sio_rx_filter`

## Requirements
- R1: After reset, `out_valid`, `out_data` and `out_bit9` are all 0 and the receiver is hunting for a falling edge.
- R2: A high sample followed by a low sample on consecutive ticks while hunting starts a frame, and the phase counter restarts at 0 on that tick. Each later bit occupies sixteen ticks measured from that point.
- R3: Each bit's value is the majority of the line samples at phases 7, 8 and 9, so a single disagreeing sample among them does not change the received bit.
- R4: A start bit that votes 1 abandons the frame with no change to any output, and a later falling edge is again accepted as a start.
- R5: With `frame11` = 0, data bits arrive LSB first into `out_data`, and `out_bit9` receives the stop bit.
- R6: With `frame11` = 1, `out_bit9` receives the ninth bit, which follows the eight data bits. The stop bit's value is ignored.
- R7: A frame that ends while `out_valid` is 1 is discarded: `out_valid`, `out_data` and `out_bit9` keep their values.
- R8: With `addr_filter` = 1, a frame is committed only when its `out_bit9` value (the stop bit in 10-bit mode, the ninth bit in 11-bit mode) is 1. Otherwise it is discarded.
- R9: `out_valid` rises in the cycle after a committed frame's last bit decision and stays high until a cycle with `out_take` = 1, after which it is 0.
- R10: After the last bit of any frame, committed or not, the receiver hunts again and needs a fresh high-to-low step. A line held low past the frame, and its later return to high, start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sample strobe, sixteen per bit period |
| rxd | input | 1 | Serial line, idle high |
| frame11 | input | 1 | 1 selects the 11-bit frame, 0 the 10-bit frame; hold stable across a frame |
| addr_filter | input | 1 | 1 commits only frames whose ninth/stop bit is 1 |
| out_take | input | 1 | Consumer clears `out_valid` |
| out_valid | output | 1 | A committed frame is held |
| out_data | output | 8 | Received data byte |
| out_bit9 | output | 1 | Ninth bit (11-bit mode) or stop bit (10-bit mode) |

## Verification
The assertions check four rules on every cycle. A held frame neither vanishes nor changes until it is taken. A take empties the holder. A frame commit always follows a bit decision. With the filter on, no frame is committed with a zero ninth/stop bit. The bench's scenarios are needed for the rest: voting that rejects a glitch, false-start rejection, correct bit order in both frame shapes, the drop of frames that arrive while the holder is full, and the refusal to start on a line that stays low.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;
  typedef enum logic [1:0] {
    RX_HUNT  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rx_state_t;

  localparam int unsigned RX_OSR    = 16;
  localparam int unsigned RX_DATA_W = 8;
endpackage

// File: rtl/sio_rx_sync.sv
module sio_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/sio_rx_phase.sv
module sio_rx_phase #(
  parameter int unsigned OSR = 16,
  localparam int unsigned CW = $clog2(OSR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic          run,
  output logic [CW-1:0] phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (tick) begin
      if (restart)
        phase <= '0;
      else if (run)
        phase <= (phase == CW'(OSR-1)) ? '0 : phase + 1'b1;
    end
  end
endmodule

// File: rtl/sio_rx_vote.sv
module sio_rx_vote #(
  parameter int unsigned OSR = 16,
  parameter int unsigned MID = 8,
  localparam int unsigned CW = $clog2(OSR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic [CW-1:0] phase,
  input  logic          rx,
  output logic          bit_stb,
  output logic          bit_val
);
  logic [CW-1:0] nxt;
  logic          s_early, s_mid;

  assign nxt = (phase == CW'(OSR-1)) ? '0 : phase + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_early <= 1'b1;
      s_mid   <= 1'b1;
    end else if (tick && run) begin
      if (nxt == CW'(MID-1)) s_early <= rx;
      if (nxt == CW'(MID))   s_mid   <= rx;
    end
  end

  assign bit_stb = tick && run && (nxt == CW'(MID+1));
  assign bit_val = (s_early & s_mid) | (s_early & rx) | (s_mid & rx);
endmodule

// File: rtl/sio_rx_filter.sv
module sio_rx_filter
  import sio_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = RX_DATA_W,
  parameter int unsigned OSR         = RX_OSR,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SR_W = DATA_W + 2,
  localparam int unsigned CW   = $clog2(OSR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              frame11,
  input  logic              addr_filter,
  input  logic              out_take,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_bit9
);
  rx_state_t     state;
  logic          rx_s, rx_prev, fall, busy;
  logic [CW-1:0] phase;
  logic          bit_stb, bit_val;
  logic [SR_W-1:0] sr;
  logic          mode11_q, last_bit, commit;
  logic [DATA_W-1:0] cap_data;
  logic          cap_bit9;

  sio_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
  );

  assign busy = (state != RX_HUNT);
  assign fall = tick16 && rx_prev && !rx_s;

  sio_rx_phase #(.OSR(OSR)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick16),
    .restart(!busy && fall), .run(busy), .phase(phase)
  );

  sio_rx_vote #(.OSR(OSR), .MID(OSR/2)) u_vote (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .run(busy),
    .phase(phase), .rx(rx_s), .bit_stb(bit_stb), .bit_val(bit_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_prev <= 1'b1;
    else if (tick16) rx_prev <= rx_s;
  end

  // sentinel: frame ends when the start zero sits at the watched slot
  assign last_bit = mode11_q ? !sr[SR_W-1] : !sr[SR_W-2];

  always_comb begin
    for (int i = 0; i < int'(DATA_W); i++) begin
      cap_data[i] = mode11_q ? sr[DATA_W-i] : sr[DATA_W-1-i];
    end
    cap_bit9 = mode11_q ? sr[0] : bit_val;
  end

  assign commit = (state == RX_BITS) && bit_stb && last_bit &&
                  !out_valid && (!addr_filter || cap_bit9);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_HUNT;
      sr       <= '1;
      mode11_q <= 1'b0;
    end else begin
      unique case (state)
        RX_HUNT: begin
          if (fall) begin
            state    <= RX_START;
            sr       <= '1;
            mode11_q <= frame11;
          end
        end
        RX_START: begin
          if (bit_stb) begin
            if (bit_val) begin
              state <= RX_HUNT;
            end else begin
              sr    <= {sr[SR_W-2:0], 1'b0};
              state <= RX_BITS;
            end
          end
        end
        RX_BITS: begin
          if (bit_stb) begin
            if (last_bit) state <= RX_HUNT;
            else          sr    <= {sr[SR_W-2:0], bit_val};
          end
        end
        default: state <= RX_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_bit9  <= 1'b0;
    end else if (commit) begin
      out_valid <= 1'b1;
      out_data  <= cap_data;
      out_bit9  <= cap_bit9;
    end else if (out_take) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_rx_filter_chk.sv
module sio_rx_filter_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_filter,
  input logic              out_take,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_bit9,
  input logic              bit_stb
);
  a_r9_hold_until_take: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_take |=> out_valid);

  a_r9_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_take |=> !out_valid);

  a_r7_held_frame_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> $stable(out_data) && $stable(out_bit9));

  a_r8_filter_blocks_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (!$past(addr_filter) || out_bit9));

  a_r3_commit_after_vote: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(bit_stb));
endmodule

bind sio_rx_filter sio_rx_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_filter(addr_filter), .out_take(out_take),
  .out_valid(out_valid), .out_data(out_data), .out_bit9(out_bit9),
  .bit_stb(bit_stb)
);

// File: tb/sio_rx_filter_test.sv
`timescale 1ns/1ps
module sio_rx_filter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic frame11 = 1'b0;
  logic addr_filter = 1'b0;
  logic out_take = 1'b0;
  logic out_valid, out_bit9;
  logic [7:0] out_data;
  logic [1:0] tdiv = 2'd0;
  logic tick16;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] last_data = 8'h00;
  logic last_b9 = 1'b0;

  always #2.5 clk = ~clk;
  always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick16 = (tdiv == 2'd3);

  sio_rx_filter uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .frame11(frame11), .addr_filter(addr_filter), .out_take(out_take),
    .out_valid(out_valid), .out_data(out_data), .out_bit9(out_bit9)
  );

  // {frame11, filter, data[7:0], ninth, stop, expect_commit}
  localparam int NV = 10;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b1},
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1},
    {1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b1},
    {1'b0, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b1},
    {1'b0, 1'b1, 8'h81, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h5A, 1'b0, 1'b1, 1'b1},
    {1'b1, 1'b0, 8'h96, 1'b1, 1'b1, 1'b1},
    {1'b1, 1'b1, 8'h42, 1'b0, 1'b1, 1'b0},
    {1'b1, 1'b1, 8'hE7, 1'b1, 1'b1, 1'b1},
    {1'b1, 1'b0, 8'h01, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic slot(input logic v);
    rxd = v;
    do @(negedge clk); while (tick16 !== 1'b1);
  endtask

  task automatic slots(input logic v, input int n);
    for (int i = 0; i < n; i++) slot(v);
  endtask

  task automatic send_bit(input logic b, input int glitch);
    for (int s = 0; s < 16; s++) slot((s == glitch) ? ~b : b);
  endtask

  task automatic send_frame(input logic f11, input logic [7:0] d, input logic b9,
                            input logic stp, input int glitch, input int tail);
    send_bit(1'b0, glitch);
    for (int i = 0; i < 8; i++) send_bit(d[i], glitch);
    if (f11) send_bit(b9, glitch);
    send_bit(stp, glitch);
    slots(1'b1, tail);
  endtask

  task automatic take();
    @(negedge clk); out_take = 1'b1;
    @(negedge clk); out_take = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_store(input string req, input logic [7:0] d, input logic b9);
    check(out_valid === 1'b1 && out_data === d && out_bit9 === b9, req,
          {7'd0, out_valid, out_data}, {7'd0, 1'b1, d});
    check(out_bit9 === b9, req, {15'd0, out_bit9}, {15'd0, b9});
    last_data = d;
    last_b9   = b9;
  endtask

  task automatic expect_none(input string req);
    check(out_valid === 1'b0 && out_data === last_data && out_bit9 === last_b9, req,
          {6'd0, out_valid, out_bit9, out_data}, {6'd0, 1'b0, last_b9, last_data});
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    check(out_valid === 1'b0 && out_data === 8'h00 && out_bit9 === 1'b0, "R1",
          {7'd0, out_valid, out_data}, 16'h0000);
    rst_n = 1'b1;
    slots(1'b1, 32);

    // table: R2 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      logic [12:0] e;
      e = VEC[v];
      frame11     = e[12];
      addr_filter = e[11];
      take();
      send_frame(e[12], e[10:3], e[2], e[1], 99, 40);
      if (e[0]) expect_store(e[12] ? "R6" : "R5", e[10:3], e[12] ? e[2] : e[1]);
      else      expect_none("R8");
    end

    frame11 = 1'b0;
    addr_filter = 1'b0;

    // R4 false start: short low pulse, then a real frame still accepted
    take();
    slots(1'b0, 6);
    slots(1'b1, 40);
    expect_none("R4");
    send_frame(1'b0, 8'h6D, 1'b0, 1'b1, 99, 40);
    expect_store("R4", 8'h6D, 1'b1);

    // R3 single disagreeing sample at phase 8 of every bit
    take();
    send_frame(1'b0, 8'hC3, 1'b0, 1'b1, 8, 40);
    expect_store("R3", 8'hC3, 1'b1);

    // R7 frame completing while holder is full is dropped
    send_frame(1'b0, 8'h11, 1'b0, 1'b0, 99, 40);
    check(out_valid === 1'b1 && out_data === 8'hC3 && out_bit9 === 1'b1, "R7",
          {7'd0, out_valid, out_data}, {7'd0, 1'b1, 8'hC3});

    // R9 take clears valid, data retained
    take();
    check(out_valid === 1'b0 && out_data === 8'hC3, "R9",
          {7'd0, out_valid, out_data}, {7'd0, 1'b0, 8'hC3});

    // R10 line low after frame, then high: no new frame
    send_frame(1'b0, 8'h20, 1'b0, 1'b0, 99, 0);
    slots(1'b0, 8);
    expect_store("R10", 8'h20, 1'b0);
    take();
    slots(1'b0, 30);
    slots(1'b1, 40);
    expect_none("R10");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule